// File: doc/BRIEF.md
# Byte Order Conversion Unit

This unit executes the endianness-conversion instruction of a packet-filter virtual machine. It receives an 8-bit opcode, a 32-bit immediate and the 64-bit value of the destination register. It returns the converted destination value and a flag that marks an illegal instruction. It does not read a source register, and it does not use the immediate as an operand. The immediate only selects how many low bytes take part.

The decoder accepts the instruction only when two conditions hold: the instruction class is the 32-bit ALU class and the operation nibble marks a byte swap. Opcode bit 3 then picks the target order. The unit treats the host as little endian. A little-endian conversion therefore keeps the low bytes and clears the rest. A big-endian conversion reverses the low bytes and clears the rest. The conversions "from" an order use the same encodings as the conversions "to" that order.

The result is held in one register stage with a valid/ready handshake on both sides.

Top module: `bswap_unit`

## Requirements
- R1: The opcode is legal only when bits 2:0 equal 3'h4 (32-bit ALU class) and bits 7:4 equal 4'hd (byte swap); bit 3 is free. Any other opcode sets `out_illegal` to 1 and makes `out_dst` equal to the input `in_dst` unchanged.
- R2: The immediate must equal 16, 32 or 64. Any other value sets `out_illegal` to 1 and leaves `in_dst` unchanged at `out_dst`.
- R3: With opcode bit 3 = 0 (little endian, also used for "from little endian"), a width of N bits copies `in_dst[N-1:0]` to the output and clears the bits above N.
- R4: With opcode bit 3 = 1 (big endian, also used for "from big endian"), a width of N bits writes the bytes of `in_dst[N-1:0]` in reverse order into the output's low N bits and clears the bits above N.
- R5: All 32 bits of the immediate take part in the width check. A value that matches a legal width only in its low bits, such as 0x00010010, is illegal.
- R6: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears at the output with `out_valid` high after exactly that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_dst` and `out_illegal` stay stable and `in_ready` is low.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1. When an output is consumed and no new input arrives in the same cycle, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_opcode | input | 8 | Instruction opcode byte |
| in_imm | input | 32 | Immediate (swap width) |
| in_dst | input | 64 | Destination register value |
| out_valid | output | 1 | Result held at the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_dst | output | 64 | Converted destination value |
| out_illegal | output | 1 | Instruction was not a legal byte swap |

## Verification
The hardest case to reach is a new instruction accepted in the same cycle the held result is consumed while the consumer keeps stalling in an irregular pattern. That pattern must not drop or repeat a result. To reach it, the bench drives `out_ready` from a random pattern and offers instructions back to back. A queue-based model pairs each accepted instruction with the result that comes out later. Directed cases cover each width and order with random data, opcodes that differ from a legal one by a single field, and immediates that look almost legal.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
    localparam int OP_W      = 8;
    localparam int IMM_W     = 32;
    localparam logic [2:0] CLASS_ALU32 = 3'h4;
    localparam logic [3:0] OPC_SWAP    = 4'hd;
    localparam int ORDER_BIT = 3;

    typedef enum logic [1:0] {
        SW_16 = 2'd0,
        SW_32 = 2'd1,
        SW_64 = 2'd2
    } swap_w_e;

    typedef struct packed {
        logic        vld;
        logic        ill;
        logic [63:0] dst;
    } stage_t;
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode
    import bswap_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    input  logic [IMM_W-1:0] imm,
    output logic             legal,
    output logic             big,
    output swap_w_e          width
);
    logic op_ok;
    logic imm_ok;

    always_comb begin
        op_ok  = (opcode[2:0] == CLASS_ALU32) && (opcode[7:4] == OPC_SWAP);
        big    = opcode[ORDER_BIT];
        imm_ok = 1'b1;
        width  = SW_64;
        if (imm == IMM_W'(16))      width = SW_16;
        else if (imm == IMM_W'(32)) width = SW_32;
        else if (imm == IMM_W'(64)) width = SW_64;
        else                        imm_ok = 1'b0;
        legal  = op_ok && imm_ok;
    end
endmodule

// File: rtl/bswap_core.sv
module bswap_core
    import bswap_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] d,
    input  logic              big,
    input  swap_w_e           width,
    output logic [DATA_W-1:0] res
);
    localparam int NBYTES = DATA_W / 8;

    int nb;

    always_comb begin
        case (width)
            SW_16:   nb = 2;
            SW_32:   nb = 4;
            default: nb = 8;
        endcase
        if (nb > NBYTES) nb = NBYTES;
        res = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) begin
                if (big) res[8*i +: 8] = d[8*(nb-1-i) +: 8];
                else     res[8*i +: 8] = d[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
    import bswap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_opcode,
    input  logic [31:0] in_imm,
    input  logic [63:0] in_dst,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [63:0] out_dst,
    output logic        out_illegal
);
    localparam int DATA_W = 64;

    stage_t  st_d, st_q;
    logic    legal_w;
    logic    big_w;
    swap_w_e width_w;
    logic [DATA_W-1:0] swapped_w;

    bswap_decode u_dec (
        .opcode (in_opcode),
        .imm    (in_imm),
        .legal  (legal_w),
        .big    (big_w),
        .width  (width_w)
    );

    bswap_core #(.DATA_W(DATA_W)) u_core (
        .d     (in_dst),
        .big   (big_w),
        .width (width_w),
        .res   (swapped_w)
    );

    assign in_ready    = !st_q.vld || out_ready;
    assign out_valid   = st_q.vld;
    assign out_dst     = st_q.dst;
    assign out_illegal = st_q.ill;

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.vld = 1'b0;
        if (in_valid && in_ready) begin
            st_d.vld = 1'b1;
            st_d.ill = !legal_w;
            st_d.dst = legal_w ? swapped_w : in_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_illegal));

    // R1
    illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !legal_w |=> out_illegal && (out_dst == $past(in_dst)));

    // R3
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && legal_w && (in_imm == 32'd16) |=> !out_illegal && (out_dst[63:16] == '0));

    // R4
    big16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && legal_w && in_opcode[3] && (in_imm == 32'd16)
        |=> out_dst[15:0] == {$past(in_dst[7:0]), $past(in_dst[15:8])});
endmodule

// File: tb/tb_bswap_unit.sv
`timescale 1ns/1ps
module tb_bswap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = 8'h0;
    logic [31:0] in_imm = 32'h0;
    logic [63:0] in_dst = 64'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_dst;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;  // 0 always, 1 random
    bit done = 1'b0;

    typedef struct {
        logic [63:0] dst;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    bswap_unit dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_imm(in_imm), .in_dst(in_dst),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dst(out_dst), .out_illegal(out_illegal)
    );

    function automatic exp_t model(logic [7:0] op, logic [31:0] imm, logic [63:0] d);
        exp_t e;
        int n;
        e.dst = d; e.ill = 1'b1; e.tag = "R1";
        if (!(op[2:0] == 3'b100 && op[7:4] == 4'b1101)) return e;
        if (imm == 16) n = 16;
        else if (imm == 32) n = 32;
        else if (imm == 64) n = 64;
        else begin
            e.tag = (imm[15:0] == 16 || imm[15:0] == 32 || imm[15:0] == 64) ? "R5" : "R2";
            return e;
        end
        e.ill = 1'b0;
        if (!op[3]) begin
            e.tag = "R3";
            e.dst = (d << (64 - n)) >> (64 - n);
        end else begin
            e.tag = "R4";
            e.dst = 64'h0;
            for (int k = 0; k < n / 8; k++)
                e.dst = e.dst | (((d >> (8 * k)) & 64'hff) << (8 * (n / 8 - 1 - k)));
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard sampled on the falling edge
    bit          prev_acc = 1'b0;
    bit          prev_pop = 1'b0;
    bit          prev_hold = 1'b0;
    logic [64:0] held;
    logic [7:0]  op_s;
    logic [31:0] imm_s;
    logic [63:0] dst_s;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_acc)
                check(out_valid === 1'b1, "R6", {64'h0, out_valid}, 65'h1);
            else if (prev_pop)
                check(out_valid === 1'b0, "R8", {64'h0, out_valid}, 65'h0);
            if (prev_hold) begin
                check({out_illegal, out_dst} === held && out_valid, "R7", {out_illegal, out_dst}, held);
                check(in_ready === 1'b0 || out_ready, "R7", {64'h0, in_ready}, 65'h0);
            end
            if (out_valid && out_ready) begin
                if (q.size() == 0) check(1'b0, "R6", 65'h1, 65'h0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    check({out_illegal, out_dst} === {e.ill, e.dst}, e.tag,
                          {out_illegal, out_dst}, {e.ill, e.dst});
                end
            end
            prev_hold = out_valid && !out_ready;
            held      = {out_illegal, out_dst};
            prev_pop  = out_valid && out_ready;
            prev_acc  = in_valid && in_ready;
            if (prev_acc) begin
                op_s = in_opcode; imm_s = in_imm; dst_s = in_dst;
                q.push_back(model(op_s, imm_s, dst_s));
            end
        end
    end

    // consumer
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = (ready_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
        end
    end

    task automatic send(logic [7:0] op, logic [31:0] imm, logic [63:0] d);
        in_valid = 1'b1; in_opcode = op; in_imm = imm; in_dst = d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 50000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(out_valid === 1'b0, "R8", {64'h0, out_valid}, 65'h0);
        check(in_ready === 1'b1, "R8", {64'h0, in_ready}, 65'h1);
        @(posedge clk); #1;
        // R3 R4 every width and order
        for (int w = 0; w < 3; w++) begin
            send(8'hd4, 32'd16 << w, r64());
            send(8'hdc, 32'd16 << w, r64());
        end
        send(8'hdc, 32'd32, 64'h0123456789abcdef);
        // R1 illegal opcodes
        send(8'hdf, 32'd16, r64());
        send(8'hc4, 32'd32, r64());
        send(8'h54, 32'd64, r64());
        send(8'hd5, 32'd64, r64());
        // R2 R5 illegal immediates
        send(8'hd4, 32'd0, r64());
        send(8'hdc, 32'd8, r64());
        send(8'hdc, 32'd17, r64());
        send(8'hd4, 32'hffffffff, r64());
        send(8'hdc, 32'h00010010, r64());
        send(8'hd4, 32'h80000040, r64());
        // random with stalls
        ready_mode = 1;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] op;
            logic [31:0] imm;
            op  = ($urandom_range(0, 4) == 0) ? 8'($urandom()) : ($urandom_range(0, 1) ? 8'hdc : 8'hd4);
            imm = ($urandom_range(0, 5) == 0) ? $urandom() : (32'd16 << $urandom_range(0, 2));
            send(op, imm, r64());
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(posedge clk);
            #0;
        end
        ready_mode = 0;
        repeat (6) @(posedge clk);
        check(q.size() == 0, "R6", 65'(q.size()), 65'h0);
        finish_run();
    end
endmodule